// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a pipelined synchronous SRAM. Reads and writes can follow each other on every clock with no idle bus cycle between them. A new operation is loaded when the clock enable and the load/advance strobe are both low at a rising edge. Its address is captured at that edge. The data for that operation is handled two active edges later, whether it is a read or a write. A read result is placed in the output register at that edge. A write takes its data word and byte enables at that edge. Because both directions use the same data slot, a mixed stream of reads and writes never leaves a gap on the data bus.

While the strobe is held high, the block generates the next addresses of a four-beat wrapping burst from the last loaded start address. A static select chooses one of two orders. The linear order adds the beat number to the start. The interleaved order XORs the beat number into the start.

The clock enable can freeze the whole pipeline for any number of cycles. A sleep request puts the block to sleep after two edges and keeps the array contents. It wakes the block two edges after the request is released. The data bus is modelled as separate input and output ports. An output-valid flag stands in for the tri-state pad.

Top module: `zt_sync_sram`

## Requirements
- R1: While reset is high and after it is released, with no read issued, `dout_oe` is 0 and `dout` is 0.
- R2: An edge with `cke_n` high is ignored entirely. No operation is loaded, no pipeline stage advances, no write commits, and the output holds its value.
- R3: An edge with `cke_n` low and `adv_n` low loads a new operation. `cs_n` high makes it a deselect, whose data slot leaves the output undriven. Otherwise `we_n` high makes it a read and `we_n` low makes it a write.
- R4: Read data appears at the second active edge after the address edge. It is shown only while the asynchronous `oe_n` is low. Otherwise `dout_oe` is 0 and `dout` is 0.
- R5: Write data and `bw_n` are sampled at the second active edge after the address edge. Bit i of `bw_n` low writes byte i, which is `din[8i+7:8i]`. Bytes whose enable is high keep their old contents.
- R6: Reads and writes may alternate on consecutive edges with no idle cycle. A read issued right after a write to the same address returns the newly written data.
- R7: With `burst_ilv` low, each edge with `adv_n` high continues the current operation type. The two low address bits become (start + beat) mod 4, and the sequence wraps to the start after the fourth beat.
- R8: With `burst_ilv` high, each burst beat uses the two low address bits start XOR beat.
- R9: A `sleep_req` that is high at two consecutive edges puts the block to sleep. While asleep, inputs are ignored, the array keeps its contents, and `dout_oe` is 0. After `sleep_req` is low at an edge, two wake edges pass before operations are accepted again.
- R10: Edges with `adv_n` high that follow a deselect continue the deselect, and the output stays undriven in those slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, active low |
| adv_n | input | 1 | Low loads a new operation; high advances the burst |
| cs_n | input | 1 | Chip select for a loaded operation, active low |
| we_n | input | 1 | High selects read, low selects write at load |
| bw_n | input | DW/8 | Byte write enables, active low, sampled in the data slot |
| addr | input | AW | Word address |
| din | input | DW | Write data, sampled in the data slot |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_req | input | 1 | Sleep request |
| dout | output | DW | Read data, zero when not driven |
| dout_oe | output | 1 | High when read data is being driven |

## Verification
Two functions can fall in the same edge. A write commits its data in the same edge where a later read is loaded or is produced. Sleep entry can also overlap operations that are still in flight during the two-edge entry window. The bench provokes the first case with back-to-back write/read pairs to the same address, partial byte writes, and long random streams that mix bursts of both orders with stalls. It provokes the second case by loading reads while the sleep request rises. A reference model in the bench predicts every output cycle. A scoreboard judges the driven flag and the data word against that prediction on each cycle.

// File: rtl/zt_pkg.sv
package zt_pkg;
  typedef enum logic [1:0] {
    PW_RUN   = 2'd0,
    PW_ENTER = 2'd1,
    PW_SLEEP = 2'd2,
    PW_WAKE  = 2'd3
  } pwr_st_e;
endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen #(
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic          ilv,
  input  logic [BB-1:0] start_in,
  output logic [BB-1:0] low_o
);
  logic [BB-1:0] start_q, beat_q, beat_nx;

  assign beat_nx = beat_q + 1'b1;

  always_comb begin
    if (load)     low_o = start_in;
    else if (ilv) low_o = start_q ^ beat_nx;
    else          low_o = start_q + beat_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (en) begin
      if (load) begin
        start_q <= start_in;
        beat_q  <= '0;
      end else begin
        beat_q <= beat_nx;
      end
    end
  end

  // R7/R8: after the last beat the sequence returns to its start address
  p_burst_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !load && beat_q == '1) |-> (low_o == start_q));
endmodule

// File: rtl/zt_sleep_ctl.sv
module zt_sleep_ctl
  import zt_pkg::*;
#(
  parameter int ENTER_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  output logic accept_o
);
  localparam int MAXC = (ENTER_CYC > WAKE_CYC) ? ENTER_CYC : WAKE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  pwr_st_e       st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PW_RUN;
      cnt_q <= '0;
    end else begin
      case (st_q)
        PW_RUN: if (sleep_req) begin
          st_q  <= PW_ENTER;
          cnt_q <= CW'(1);
        end
        PW_ENTER: begin
          if (!sleep_req) st_q <= PW_RUN;
          else if (cnt_q >= CW'(ENTER_CYC - 1)) st_q <= PW_SLEEP;
          else cnt_q <= cnt_q + 1'b1;
        end
        PW_SLEEP: if (!sleep_req) begin
          st_q  <= PW_WAKE;
          cnt_q <= CW'(1);
        end
        PW_WAKE: begin
          if (sleep_req) st_q <= PW_SLEEP;
          else if (cnt_q >= CW'(WAKE_CYC - 1)) st_q <= PW_RUN;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= PW_RUN;
      endcase
    end
  end

  assign accept_o = (st_q == PW_RUN) || (st_q == PW_ENTER);

  // R9: sleep is left only through the wake window
  p_sleep_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == PW_SLEEP) |=> (st_q == PW_SLEEP || st_q == PW_WAKE));
endmodule

// File: rtl/zt_byte_ram.sv
module zt_byte_ram #(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic [LANES-1:0]   we,
  input  logic               re,
  input  logic [AW-1:0]      addr,
  input  logic [LANES*8-1:0] wdata,
  output logic [LANES*8-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*8 +: 8];
      if (re)    lane_q    <= mem[addr];
    end
    assign rdata[g*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/zt_sync_sram.sv
module zt_sync_sram #(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int BB        = 2,
  parameter int ENTER_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke_n,
  input  logic            adv_n,
  input  logic            cs_n,
  input  logic            we_n,
  input  logic [DW/8-1:0] bw_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   din,
  input  logic            oe_n,
  input  logic            burst_ilv,
  input  logic            sleep_req,
  output logic [DW-1:0]   dout,
  output logic            dout_oe
);
  localparam int LANES = DW / 8;

  logic          accept, en;
  logic [BB-1:0] low;
  logic          a_vld_q, a_wr_q, b_vld_q, b_wr_q, rd_drv_q;
  logic [AW-1:0] a_addr_q, b_addr_q;
  logic [DW-1:0] ram_q;
  logic [LANES-1:0] lane_we;
  logic          ram_re;

  zt_sleep_ctl #(.ENTER_CYC(ENTER_CYC), .WAKE_CYC(WAKE_CYC)) u_sleep (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .accept_o(accept)
  );

  assign en = !cke_n && accept;

  zt_burst_gen #(.BB(BB)) u_burst (
    .clk(clk), .rst(rst), .en(en), .load(!adv_n), .ilv(burst_ilv),
    .start_in(addr[BB-1:0]), .low_o(low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld_q  <= 1'b0;
      a_wr_q   <= 1'b0;
      a_addr_q <= '0;
      b_vld_q  <= 1'b0;
      b_wr_q   <= 1'b0;
      b_addr_q <= '0;
      rd_drv_q <= 1'b0;
    end else if (en) begin
      b_vld_q  <= a_vld_q;
      b_wr_q   <= a_wr_q;
      b_addr_q <= a_addr_q;
      rd_drv_q <= b_vld_q && !b_wr_q;
      if (!adv_n) begin
        a_vld_q  <= !cs_n;
        a_wr_q   <= !we_n;
        a_addr_q <= {addr[AW-1:BB], low};
      end else begin
        a_addr_q <= {a_addr_q[AW-1:BB], low};
      end
    end
  end

  assign lane_we = {LANES{en && b_vld_q && b_wr_q}} & ~bw_n;
  assign ram_re  = en && b_vld_q && !b_wr_q;

  zt_byte_ram #(.AW(AW), .LANES(LANES)) u_ram (
    .clk(clk), .we(lane_we), .re(ram_re), .addr(b_addr_q),
    .wdata(din), .rdata(ram_q)
  );

  assign dout_oe = rd_drv_q && !oe_n && accept;
  assign dout    = dout_oe ? ram_q : '0;

  // R2: a stalled edge leaves every pipeline stage untouched
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && cke_n) |=> ($stable(a_vld_q) && $stable(b_vld_q) && $stable(a_addr_q)
                         && $stable(rd_drv_q)));

  // R4: the drive flag only rises after a read reached the data slot
  p_drv_from_read_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_drv_q) |-> $past(en && b_vld_q && !b_wr_q));
endmodule

// File: tb/zt_sync_sram_tb_top.sv
module zt_sync_sram_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke_n = 1'b0, adv_n = 1'b0, cs_n = 1'b1, we_n = 1'b1;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic oe_n = 1'b0, burst_ilv = 1'b0, sleep_req = 1'b0;
  logic [DW-1:0] dout;
  logic dout_oe;

  always #2 clk = ~clk;

  zt_sync_sram #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .cke_n(cke_n), .adv_n(adv_n), .cs_n(cs_n), .we_n(we_n),
    .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n), .burst_ilv(burst_ilv),
    .sleep_req(sleep_req), .dout(dout), .dout_oe(dout_oe)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  string cur_tag = "R1";

  typedef struct { logic oe; logic [DW-1:0] d; string tag; } exp_t;
  exp_t exp_q[$];

  // reference model state
  logic [DW-1:0] mmem [1 << AW];
  logic ma_vld = 0, ma_wr = 0, mb_vld = 0, mb_wr = 0, mdrv = 0;
  logic [AW-1:0] ma_addr = '0, mb_addr = '0;
  logic [1:0] mstart = '0, mbeat = '0;
  logic [DW-1:0] mout = '0;
  int mst = 0; // 0 run, 1 entering, 2 asleep, 3 waking

  task automatic model_step();
    bit act;
    act = !cke_n && (mst < 2);
    if (act) begin
      if (mb_vld && mb_wr) begin
        for (int i = 0; i < 4; i++)
          if (!bw_n[i]) mmem[mb_addr][i*8 +: 8] = din[i*8 +: 8];
      end
      if (mb_vld && !mb_wr) mout = mmem[mb_addr];
      mdrv = mb_vld && !mb_wr;
      mb_vld = ma_vld; mb_wr = ma_wr; mb_addr = ma_addr;
      if (!adv_n) begin
        ma_vld = !cs_n; ma_wr = !we_n; ma_addr = addr;
        mstart = addr[1:0]; mbeat = 0;
      end else begin
        mbeat = mbeat + 1;
        ma_addr[1:0] = burst_ilv ? (mstart ^ mbeat) : (mstart + mbeat);
      end
    end
    case (mst)
      0: mst = sleep_req ? 1 : 0;
      1: mst = sleep_req ? 2 : 0;
      2: mst = sleep_req ? 2 : 3;
      default: mst = sleep_req ? 2 : 0;
    endcase
  endtask

  task automatic cyc(input logic c_cke_n, input logic c_adv_n, input logic c_cs_n,
                     input logic c_we_n, input logic [3:0] c_bw_n, input logic [AW-1:0] c_addr,
                     input logic c_oe_n, input logic c_ilv, input logic c_sr);
    exp_t e;
    @(negedge clk);
    cke_n = c_cke_n; adv_n = c_adv_n; cs_n = c_cs_n; we_n = c_we_n; bw_n = c_bw_n;
    addr = c_addr; din = $urandom; oe_n = c_oe_n; burst_ilv = c_ilv; sleep_req = c_sr;
    @(posedge clk);
    model_step();
    e.oe = mdrv && !c_oe_n && (mst < 2);
    e.d = e.oe ? mout : '0;
    e.tag = cur_tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 1, 4'hF, '0, 0, 0, 0);
  endtask
  task automatic ld_rd(input logic [AW-1:0] a, input logic ilv);
    cyc(0, 0, 0, 1, 4'hF, a, 0, ilv, 0);
  endtask
  task automatic ld_wr(input logic [AW-1:0] a, input logic [3:0] bw, input logic ilv);
    cyc(0, 0, 0, 0, bw, a, 0, ilv, 0);
  endtask
  task automatic adv(input logic [3:0] bw, input logic ilv);
    cyc(0, 1, 0, 0, bw, '0, 0, ilv, 0);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (dout_oe !== e.oe || dout !== e.d) begin
        failures++;
        $display("FAIL %s: oe act=%0b exp=%0b data act=%h exp=%h", e.tag, dout_oe, e.oe, dout, e.d);
      end
    end
  end

  task automatic direct_chk(input bit ok, input string tag, input logic [DW-1:0] act,
                            input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%h exp=%h", tag, act, expv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    direct_chk(dout_oe === 1'b0 && dout === '0, "R1", dout, '0);
    rst = 1'b0;
    @(negedge clk);
    direct_chk(dout_oe === 1'b0 && dout === '0, "R1", dout, '0);

    // R5/R7: fill the whole array with linear write bursts
    cur_tag = "R7";
    for (int b = 0; b < (1 << AW); b += 4) begin
      ld_wr(AW'(b), 4'h0, 0);
      for (int k = 0; k < 3; k++) adv(4'h0, 0);
    end
    idle(3);

    // R6: alternating write/read on the same addresses, no idle slot
    cur_tag = "R6";
    for (int k = 0; k < 6; k++) begin
      ld_wr(AW'(8'h40 + k), 4'h0, 0);
      ld_rd(AW'(8'h40 + k), 0);
    end
    idle(3);

    // R5: partial byte writes
    cur_tag = "R5";
    ld_wr(AW'(9), 4'b1010, 0);
    ld_rd(AW'(9), 0);
    ld_wr(AW'(10), 4'b0111, 0);
    ld_rd(AW'(10), 0);
    ld_wr(AW'(11), 4'b1111, 0);
    ld_rd(AW'(11), 0);
    idle(3);

    // R7: linear read burst starting at low bits 01
    cur_tag = "R7";
    cyc(0, 0, 0, 1, 4'hF, AW'(8'h11), 0, 0, 0);
    for (int k = 0; k < 5; k++) cyc(0, 1, 0, 1, 4'hF, '0, 0, 0, 0);
    idle(3);

    // R8: interleaved write burst then interleaved read burst
    cur_tag = "R8";
    ld_wr(AW'(8'h22), 4'h0, 1);
    for (int k = 0; k < 3; k++) adv(4'h0, 1);
    cyc(0, 0, 0, 1, 4'hF, AW'(8'h21), 0, 1, 0);
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 1, 4'hF, '0, 0, 1, 0);
    idle(3);

    // R4: output enable high hides read data
    cur_tag = "R4";
    cyc(0, 0, 0, 1, 4'hF, AW'(3), 1, 0, 0);
    cyc(0, 0, 0, 1, 4'hF, AW'(4), 1, 0, 0);
    cyc(0, 0, 1, 1, 4'hF, '0, 1, 0, 0);
    cyc(0, 0, 1, 1, 4'hF, '0, 0, 0, 0);
    idle(2);

    // R2: stalls in the middle of reads and writes
    cur_tag = "R2";
    ld_wr(AW'(8'h30), 4'h0, 0);
    cyc(1, 0, 0, 1, 4'h0, AW'(8'h31), 0, 0, 0);
    cyc(1, 0, 0, 0, 4'h0, AW'(8'h32), 0, 0, 0);
    ld_rd(AW'(8'h30), 0);
    cyc(1, 0, 0, 0, 4'h0, AW'(8'h30), 0, 0, 0);
    cyc(1, 1, 0, 0, 4'h0, AW'(8'h30), 0, 0, 0);
    idle(4);

    // R3/R10: deselect followed by advance edges
    cur_tag = "R10";
    ld_rd(AW'(5), 0);
    cyc(0, 0, 1, 1, 4'hF, AW'(6), 0, 0, 0);
    for (int k = 0; k < 4; k++) cyc(0, 1, 1, 0, 4'h0, '0, 0, 0, 0);
    cur_tag = "R3";
    ld_rd(AW'(7), 0);
    idle(3);

    // R9: sleep entry with reads in flight, ignored writes while asleep/waking
    cur_tag = "R9";
    cyc(0, 0, 0, 1, 4'hF, AW'(5), 0, 0, 1);
    cyc(0, 0, 0, 1, 4'hF, AW'(6), 0, 0, 1);
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 4'h0, AW'(5), 0, 0, 1);
    cyc(0, 0, 0, 0, 4'h0, AW'(5), 0, 0, 0);
    cyc(0, 0, 0, 0, 4'h0, AW'(5), 0, 0, 0);
    ld_rd(AW'(5), 0);
    ld_rd(AW'(6), 0);
    idle(3);

    // R6: random mixed traffic with bursts, stalls and output-enable toggling
    cur_tag = "R6";
    for (int k = 0; k < 1500; k++) begin
      cyc(($urandom % 8) == 0, ($urandom % 3) == 0, ($urandom % 10) == 0, $urandom % 2,
          4'($urandom), AW'($urandom), ($urandom % 6) == 0, $urandom % 2, 0);
    end
    idle(4);

    finished = 1;
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule